// File: doc/BRIEF.md
# Sync-Headed Binary Packet Receiver

This block sits on an incoming byte stream and pulls framed binary packets out of it. A packet opens with a two-byte sync pattern, then a type byte and a count of the payload bytes that follow. The payload comes next, and a 16-bit CRC closes the packet. The receiver searches for the sync pattern and captures the header. It then consumes exactly the announced number of payload bytes and checks the CRC. At the end it raises a one-cycle status pulse that carries the type, the length and a good/bad verdict.

Payload bytes of recognised types are passed straight through on a valid/ready output stream as they arrive. Because the CRC verdict only exists after the last byte, a consumer buffers the payload and commits or drops it on the status pulse. Packets of an unrecognised type are still consumed byte for byte, guided by the length field, so that stream alignment survives. They produce neither output nor status. For the voltage-set type, the channel and the signed millivolt level are also decoded. A gap timer abandons a packet that stalls part-way.

Back-pressure rules: the input port is always ready, except while a payload byte of a recognised type is on offer. In that case `in_ready` follows `out_ready`, and the byte is taken only when both sides handshake in the same cycle. A stalled byte (valid held high) is not an input gap.

Top module: `pkt_rx`

## Requirements
- R1: Hunting accepts 0xA5 followed by 0x5A as the sync pair. A 0xA5 seen while waiting for 0x5A keeps the receiver waiting for 0x5A. Any other byte returns it to hunting for 0xA5. Bytes outside a packet produce no output.
- R2: After the sync pair, the next byte is the packet type and the one after it is the payload length (0 to 255). Exactly that many payload bytes are consumed before the CRC.
- R3: The CRC is CRC-16 with polynomial 0x1021, initial value 0xFFFF, MSB-first, no final XOR. It covers the type, length and payload bytes and arrives high byte first. `st_good` is 1 only when the received CRC matches.
- R4: For a recognised type, `st_valid` pulses for one cycle, in the cycle after the low CRC byte is accepted, together with `st_type` and `st_len`.
- R5: Types 0x01 (voltage set) and 0x02 (voltage report) are recognised. Their payload bytes appear on `out_data` in arrival order, with `out_last` set on the final byte; a zero-length packet emits no bytes. Any other type is consumed silently: no output bytes, no status pulse, and a sync pattern inside its payload is not treated as a new packet.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low. Outside the payload of a recognised type, `in_ready` is high.
- R7: A good type 0x01 packet of length 4 pulses `st_vset_valid` with `st_valid`. `st_chan` is payload bytes 0 and 1, big-endian, and `st_level_mv` is payload bytes 2 and 3, a big-endian two's complement value in millivolts.
- R8: The gap timer arms when the first sync byte is accepted. After `TIMEOUT_CYC` consecutive cycles with `in_valid` low inside a packet, `st_timeout` pulses for one cycle and hunting restarts. A stalled byte does not count as a gap.
- R9: After reset, `in_ready` is high and `out_valid`, `st_valid`, `st_vset_valid` and `st_timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Payload byte valid |
| out_ready | input | 1 | Consumer ready for payload byte |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Final payload byte of the packet |
| st_valid | output | 1 | One-cycle packet status pulse |
| st_good | output | 1 | CRC matched |
| st_type | output | 8 | Packet type |
| st_len | output | 8 | Payload length |
| st_vset_valid | output | 1 | Decoded voltage-set fields valid |
| st_chan | output | 16 | Voltage-set channel |
| st_level_mv | output | 16 | Voltage-set level, signed millivolts |
| st_timeout | output | 1 | One-cycle pulse: partial packet abandoned |

## Verification
The bench feeds clean voltage-set and voltage-report packets. It also feeds a packet preceded by junk bytes and a doubled 0xA5, which shows whether the second-sync wait handles repeated first-sync bytes. A packet with a corrupted CRC separates a correct verdict from one that only counts bytes. An unknown-type packet whose payload contains the sync pair, followed by a good packet, shows whether skipping is driven by the length field or by re-hunting. A zero-length packet, a toggling and a long-held `out_ready`, and input gaps both mid-payload and right after the first sync byte separate a stall from a real gap and show where the timer is armed.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

  typedef enum logic [2:0] {
    S_HUNT1, S_HUNT2, S_TYPE, S_LEN, S_PAY, S_CRCH, S_CRCL
  } rx_state_e;

  localparam logic [7:0]  SYNC_A    = 8'hA5;
  localparam logic [7:0]  SYNC_B    = 8'h5A;
  localparam logic [7:0]  TYPE_VSET = 8'h01;
  localparam logic [7:0]  TYPE_VRSP = 8'h02;
  localparam logic [15:0] CRC_INIT  = 16'hFFFF;
  localparam logic [15:0] CRC_POLY  = 16'h1021;
  localparam int          VSET_LEN  = 4;

  // One byte folded into the running CRC, MSB first.
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

  function automatic logic type_known(input logic [7:0] t);
    return (t == TYPE_VSET) || (t == TYPE_VRSP);
  endfunction

endpackage

// File: rtl/pkt_rx_crc.sv
module pkt_rx_crc
  import pkt_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc <= CRC_INIT;
    else if (en)       crc <= crc_step(crc, din);
  end
endmodule

// File: rtl/pkt_rx_gap_timer.sv
module pkt_rx_gap_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic busy,
  output logic expire
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  assign expire = armed && !busy && (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !armed || busy || expire) cnt <= '0;
    else                                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pkt_rx.sv
module pkt_rx
  import pkt_rx_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              st_valid,
  output logic              st_good,
  output logic [7:0]        st_type,
  output logic [7:0]        st_len,
  output logic              st_vset_valid,
  output logic [15:0]       st_chan,
  output logic signed [15:0] st_level_mv,
  output logic              st_timeout
);
  localparam int FLD_W = 8 * VSET_LEN;

  rx_state_e         state;
  logic [7:0]        typ_q, len_q, cnt_q, crc_hi_q;
  logic [FLD_W-1:0]  fld_q;
  logic [15:0]       crc_run;
  logic              known, fwd, acc, crc_clr, crc_en, expire, crc_ok;

  assign known     = type_known(typ_q);
  assign fwd       = (state == S_PAY) && known;
  assign in_ready  = fwd ? out_ready : 1'b1;
  assign out_valid = in_valid && fwd;
  assign out_data  = in_data;
  assign out_last  = fwd && (cnt_q == len_q - 8'd1);
  assign acc       = in_valid && in_ready;
  assign crc_clr   = acc && (state == S_HUNT2) && (in_data == SYNC_B);
  assign crc_en    = acc && ((state == S_TYPE) || (state == S_LEN) || (state == S_PAY));
  assign crc_ok    = ({crc_hi_q, in_data} == crc_run);

  pkt_rx_crc crc_i (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .din(in_data), .crc(crc_run)
  );

  pkt_rx_gap_timer #(.LIMIT(TIMEOUT_CYC)) gap_i (
    .clk(clk), .rst_n(rst_n), .armed(state != S_HUNT1), .busy(in_valid), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= S_HUNT1;
      typ_q         <= '0;
      len_q         <= '0;
      cnt_q         <= '0;
      crc_hi_q      <= '0;
      fld_q         <= '0;
      st_valid      <= 1'b0;
      st_good       <= 1'b0;
      st_type       <= '0;
      st_len        <= '0;
      st_vset_valid <= 1'b0;
      st_chan       <= '0;
      st_level_mv   <= '0;
      st_timeout    <= 1'b0;
    end else begin
      st_valid      <= 1'b0;
      st_vset_valid <= 1'b0;
      st_timeout    <= 1'b0;
      if (expire) begin
        state      <= S_HUNT1;
        st_timeout <= 1'b1;
      end else if (acc) begin
        unique case (state)
          S_HUNT1: if (in_data == SYNC_A) state <= S_HUNT2;
          S_HUNT2: begin
            if (in_data == SYNC_B)      state <= S_TYPE;
            else if (in_data != SYNC_A) state <= S_HUNT1;
          end
          S_TYPE: begin
            typ_q <= in_data;
            state <= S_LEN;
          end
          S_LEN: begin
            len_q <= in_data;
            cnt_q <= '0;
            fld_q <= '0;
            state <= (in_data == 8'd0) ? S_CRCH : S_PAY;
          end
          S_PAY: begin
            cnt_q <= cnt_q + 8'd1;
            if (cnt_q < 8'(VSET_LEN)) fld_q <= {fld_q[FLD_W-9:0], in_data};
            if (cnt_q == len_q - 8'd1) state <= S_CRCH;
          end
          S_CRCH: begin
            crc_hi_q <= in_data;
            state    <= S_CRCL;
          end
          S_CRCL: begin
            state <= S_HUNT1;
            if (known) begin
              st_valid      <= 1'b1;
              st_good       <= crc_ok;
              st_type       <= typ_q;
              st_len        <= len_q;
              st_vset_valid <= crc_ok && (typ_q == TYPE_VSET) && (len_q == 8'(VSET_LEN));
              st_chan       <= fld_q[FLD_W-1:FLD_W-16];
              st_level_mv   <= fld_q[15:0];
            end
          end
          default: state <= S_HUNT1;
        endcase
      end
    end
  end
endmodule

// File: rtl/pkt_rx_chk.sv
module pkt_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic st_valid,
  input logic st_good,
  input logic st_vset_valid,
  input logic st_timeout
);
  // R6
  bp_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R5
  out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);

  // R4
  st_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> !st_valid);

  // R7
  vset_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_vset_valid |-> (st_valid && st_good));

  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_timeout |-> (!st_valid && !out_valid));

  // R8
  abort_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_timeout |=> !out_valid);
endmodule

bind pkt_rx pkt_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .st_valid(st_valid),
  .st_good(st_good), .st_vset_valid(st_vset_valid), .st_timeout(st_timeout)
);

// File: tb/pkt_rx_tb_top.sv
module pkt_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_last;
  logic [7:0]  out_data;
  logic        st_valid, st_good, st_vset_valid, st_timeout;
  logic [7:0]  st_type, st_len;
  logic [15:0] st_chan;
  logic signed [15:0] st_level_mv;

  int n_chk = 0, n_fail = 0;
  int exp_to = 0, seen_to = 0;
  int bp_mode = 0;
  bit hold_low = 0;
  logic [8:0]  exp_pay[$];
  logic [49:0] exp_st[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_rx #(.TIMEOUT_CYC(TMO)) dut_i (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_pkt(input logic [7:0] t, input logic [7:0] pl[$], input bit corrupt);
    logic [15:0] c;
    logic [7:0]  len;
    bit good, known, vset;
    len = 8'(pl.size());
    c = 16'hFFFF;
    c = ref_crc(c, t);
    c = ref_crc(c, len);
    foreach (pl[i]) c = ref_crc(c, pl[i]);
    good  = !corrupt;
    if (corrupt) c = c ^ 16'h0001;
    known = (t == 8'h01) || (t == 8'h02);
    vset  = good && (t == 8'h01) && (len == 8'd4);
    if (known) begin
      foreach (pl[i]) exp_pay.push_back({(i == pl.size() - 1), pl[i]});
      exp_st.push_back({good, t, len, vset,
                        (len >= 4) ? {pl[0], pl[1], pl[2], pl[3]} : 32'h0});
    end
    send_byte(8'hA5);
    send_byte(8'h5A);
    send_byte(t);
    send_byte(len);
    foreach (pl[i]) send_byte(pl[i]);
    send_byte(c[15:8]);
    send_byte(c[7:0]);
  endtask

  // Consumer readiness
  initial begin
    int tick = 0;
    forever begin
      @(posedge clk);
      #1;
      tick++;
      out_ready = hold_low ? 1'b0 : (bp_mode == 1) ? (tick % 3 != 0) : 1'b1;
    end
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (exp_pay.size() == 0) check(0, "R5 unexpected payload byte", {out_last, out_data}, 0);
        else begin
          logic [8:0] e;
          e = exp_pay.pop_front();
          check({out_last, out_data} == e, "R5 payload byte/last", {out_last, out_data}, e);
        end
      end
      if (st_valid) begin
        if (exp_st.size() == 0) check(0, "R4 unexpected status", st_type, 0);
        else begin
          logic [49:0] e;
          e = exp_st.pop_front();
          check(st_good == e[49], "R3 crc verdict", st_good, e[49]);
          check({st_type, st_len} == e[48:33], "R4 status type/len", {st_type, st_len}, e[48:33]);
          check(st_vset_valid == e[32], "R7 vset valid", st_vset_valid, e[32]);
          if (e[32]) check({st_chan, st_level_mv} == e[31:0], "R7 chan/level", {st_chan, st_level_mv}, e[31:0]);
        end
      end
      if (st_timeout) seen_to++;
    end
  end

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] pl[$];
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
    check({out_valid, st_valid, st_vset_valid, st_timeout} == 4'b0, "R9 outputs low",
          {out_valid, st_valid, st_vset_valid, st_timeout}, 0);
    @(posedge clk); #1;

    // R7 voltage set: chan 3, level -1250 mV
    pl = '{8'h00, 8'h03, 8'hFB, 8'h1E};
    send_pkt(8'h01, pl, 0);
    idle(3);

    // R5 R6 voltage report under toggling back-pressure
    bp_mode = 1;
    pl = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60};
    send_pkt(8'h02, pl, 0);
    bp_mode = 0;
    idle(3);

    // R1 junk then doubled first sync byte
    send_byte(8'h33); send_byte(8'hA5); send_byte(8'h77); send_byte(8'hA5);
    pl = '{8'h01, 8'h02, 8'h03, 8'h04};
    send_pkt(8'h01, pl, 0);
    idle(3);

    // R3 bad CRC
    pl = '{8'h00, 8'h07, 8'h00, 8'h64};
    send_pkt(8'h01, pl, 1);
    idle(3);

    // R5 unknown type with embedded sync pair, then a good packet
    pl = '{8'hA5, 8'h5A, 8'h01, 8'h00, 8'h12, 8'h34, 8'h56};
    send_pkt(8'h7E, pl, 0);
    pl = '{8'h00, 8'h09, 8'h80, 8'h00};
    send_pkt(8'h01, pl, 0);
    idle(3);

    // R2 zero-length packet
    pl = {};
    send_pkt(8'h02, pl, 0);
    idle(3);

    // R8 long stall mid-payload is not a gap
    pl = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
    fork
      send_pkt(8'h02, pl, 0);
      begin idle(7); hold_low = 1; idle(3 * TMO); hold_low = 0; end
    join
    idle(3);
    check(seen_to == 0, "R8 stall not a gap", seen_to, 0);

    // R8 gap mid-payload aborts
    send_byte(8'hA5); send_byte(8'h5A); send_byte(8'h01); send_byte(8'h04);
    exp_pay.push_back({1'b0, 8'h11}); exp_pay.push_back({1'b0, 8'h22});
    send_byte(8'h11); send_byte(8'h22);
    exp_to++;
    idle(TMO + 4);
    check(seen_to == exp_to, "R8 timeout after payload gap", seen_to, exp_to);

    // R8 timer armed from first sync byte
    send_byte(8'hA5);
    exp_to++;
    idle(TMO + 4);
    check(seen_to == exp_to, "R8 timeout after first sync", seen_to, exp_to);

    // R1 R8 recovery
    pl = '{8'h7F, 8'hFF, 8'h7F, 8'hFF};
    send_pkt(8'h01, pl, 0);
    idle(6);

    check(exp_pay.size() == 0, "R5 all payload seen", exp_pay.size(), 0);
    check(exp_st.size() == 0, "R4 all status seen", exp_st.size(), 0);
    check(seen_to == exp_to, "R8 timeout count", seen_to, exp_to);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule